// File: doc/BRIEF.md
# Processor-to-Host Message CSR Unit

This unit connects a small processor core to a host-side test harness. The core reports progress and results by writing one dedicated control/status register, the to-host register. Each accepted write becomes a typed message: the two type bits say whether the 16-bit payload is an exit code, a character to print, or one half of a 32-bit integer to print. The messages are queued in order for the host, which pops them with a valid/dequeue handshake. Printing a full 32-bit integer therefore takes two separate writes: the low half first, then the high half. An exit payload of zero means the program passed, and any other value means it failed.

The unit also owns the core's run control. After reset the core is held stopped with its run output low. A start command from the host carries the start address. One cycle after the command, the unit drives that address on the PC output and raises run. When an exit message is queued, run drops and the core stops. From then on, writes are ignored until the host issues a new start command. A full queue stalls the core by pulling the write-ready signal low.

Top module: `hostmsg_csr_unit`

## Requirements
- R1: After reset, `core_run` is 0, `core_pc` is 0, `msg_valid` is 0 and `csr_wr_ready` is 1.
- R2: A start command accepted while the core is stopped sets `core_pc` to `start_addr` and raises `core_run` in the following cycle.
- R3: A start command that arrives while `core_run` is high changes neither `core_pc` nor `core_run`.
- R4: An accepted write to the to-host address (default 0x780) produces one message, with `msg_kind` equal to bits 17:16 of the written value and `msg_payload` equal to bits 15:0; bits 31:18 have no effect.
- R5: The message kinds are encoded as 0 = exit code, 1 = print character, 2 = low 16 bits of an integer and 3 = high 16 bits; messages leave in the order they were written, so a low/high pair arrives low first.
- R6: The queue holds 4 messages by default. When it is full, a to-host write sees `csr_wr_ready` low and waits without loss, and it completes once the host dequeues a message.
- R7: A write to any CSR address other than the to-host address produces no message.
- R8: Once an exit message (kind 0) is queued, `core_run` is low from the next cycle on, and the exit payload (0 for pass, nonzero for fail) reaches the host unchanged.
- R9: After an exit, to-host writes produce no message until a new start command is given; that command restarts the core at its new address.
- R10: To-host writes made before the first start command produce no message.
- R11: While `msg_valid` is high and `msg_deq` is low, `msg_kind` and `msg_payload` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr_valid | input | 1 | The core presents a CSR write |
| csr_wr_addr | input | 12 | CSR address of the write |
| csr_wr_data | input | 32 | Value written |
| csr_wr_ready | output | 1 | Write can complete this cycle (low when the queue is full and the write targets the to-host register) |
| start_valid | input | 1 | Host start command |
| start_addr | input | 32 | Start address carried by the command |
| core_run | output | 1 | Core is released from reset and running |
| core_pc | output | 32 | Start PC given to the core |
| msg_valid | output | 1 | A message is waiting for the host |
| msg_kind | output | 2 | Type of the head message |
| msg_payload | output | 16 | Data of the head message |
| msg_deq | input | 1 | Host pops the head message |

## Verification
The bench covers these corner cases:
- **Queue overflow.** It fills the queue and then offers a fifth write. A design that dropped or overwrote that write would lose a character, or return the messages out of order, after the stall clears.
- **Stray writes.** It writes the to-host register before the first start command and again after an exit. A design that ignored run state would deliver these stray messages.
- **Bits outside the fields.** It writes values with the upper bits set. A decoder with a shifted field would report the wrong kind.
- **Restart.** It sends a start command while the core runs, which must leave the PC alone. It then sends a start command after a halt, which must restart the core at the new address.

// File: rtl/hostmsg_pkg.sv
package hostmsg_pkg;

  typedef enum logic [1:0] {
    KIND_EXIT    = 2'd0,
    KIND_CHAR    = 2'd1,
    KIND_INT_LO  = 2'd2,
    KIND_INT_HI  = 2'd3
  } msg_kind_e;

  typedef struct packed {
    msg_kind_e   kind;
    logic [15:0] payload;
  } msg_t;

  typedef enum logic [1:0] {
    RC_IDLE = 2'd0,
    RC_RUN  = 2'd1,
    RC_HALT = 2'd2
  } run_state_e;

endpackage

// File: rtl/hostmsg_rst_sync.sv
module hostmsg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/hostmsg_decode.sv
module hostmsg_decode
  import hostmsg_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter logic [11:0] TOHOST_ADDR = 12'h780
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [17:0]       data_i,
  output logic              hit_o,
  output msg_t              msg_o,
  output logic              is_exit_o
);
  always_comb begin
    hit_o       = (addr_i == ADDR_W'(TOHOST_ADDR));
    msg_o.kind  = msg_kind_e'(data_i[17:16]);
    msg_o.payload = data_i[15:0];
    is_exit_o   = (msg_o.kind == KIND_EXIT);
  end
endmodule

// File: rtl/hostmsg_fifo.sv
module hostmsg_fifo
  import hostmsg_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enq_i,
  input  msg_t                       data_i,
  input  logic                       deq_i,
  output msg_t                       head_o,
  output logic                       full_o,
  output logic                       empty_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

  msg_t             mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             push, pop;

  always_comb begin
    empty_o = (count_q == '0);
    full_o  = (count_q == CNT_W'(DEPTH));
    push    = enq_i & ~full_o;
    pop     = deq_i & ~empty_o;

    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (push) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    if (pop)  rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;

    unique case ({push, pop})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic entry_en;
    assign entry_en = push && (wr_ptr_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (entry_en) mem_q[i] <= data_i;
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign level_o = count_q;
endmodule

// File: rtl/hostmsg_runctl.sv
module hostmsg_runctl
  import hostmsg_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [PC_W-1:0] start_addr_i,
  input  logic            halt_i,
  output logic            run_o,
  output logic [PC_W-1:0] pc_o
);
  run_state_e      state_q, state_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic            pc_en;

  always_comb begin
    state_d = state_q;
    pc_en   = 1'b0;
    unique case (state_q)
      RC_IDLE, RC_HALT: begin
        if (start_i) begin
          state_d = RC_RUN;
          pc_en   = 1'b1;
        end
      end
      RC_RUN: begin
        if (halt_i) state_d = RC_HALT;
      end
      default: state_d = RC_IDLE;
    endcase
    pc_d = pc_en ? start_addr_i : pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RC_IDLE;
      pc_q    <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
    end
  end

  assign run_o = (state_q == RC_RUN);
  assign pc_o  = pc_q;
endmodule

// File: rtl/hostmsg_csr_unit.sv
module hostmsg_csr_unit
  import hostmsg_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          DATA_W      = 32,
  parameter int          PC_W        = 32,
  parameter int          DEPTH       = 4,
  parameter logic [11:0] TOHOST_ADDR = 12'h780
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr_valid,
  input  logic [ADDR_W-1:0] csr_wr_addr,
  input  logic [DATA_W-1:0] csr_wr_data,
  output logic              csr_wr_ready,
  input  logic              start_valid,
  input  logic [PC_W-1:0]   start_addr,
  output logic              core_run,
  output logic [PC_W-1:0]   core_pc,
  output logic              msg_valid,
  output logic [1:0]        msg_kind,
  output logic [15:0]       msg_payload,
  input  logic              msg_deq
);
  localparam int LVL_W = $clog2(DEPTH+1);

  logic             rst_sync_n;
  logic             tohost_hit;
  logic             wr_is_exit;
  logic             wr_accept;
  logic             q_full, q_empty;
  logic [LVL_W-1:0] q_level;
  msg_t             wr_msg, head_msg;

  hostmsg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hostmsg_decode #(.ADDR_W(ADDR_W), .TOHOST_ADDR(TOHOST_ADDR)) u_dec (
    .addr_i    (csr_wr_addr),
    .data_i    (csr_wr_data[17:0]),
    .hit_o     (tohost_hit),
    .msg_o     (wr_msg),
    .is_exit_o (wr_is_exit)
  );

  assign csr_wr_ready = ~(tohost_hit & q_full);
  assign wr_accept    = csr_wr_valid & core_run & tohost_hit & ~q_full;

  hostmsg_fifo #(.DEPTH(DEPTH)) u_q (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .enq_i   (wr_accept),
    .data_i  (wr_msg),
    .deq_i   (msg_deq),
    .head_o  (head_msg),
    .full_o  (q_full),
    .empty_o (q_empty),
    .level_o (q_level)
  );

  hostmsg_runctl #(.PC_W(PC_W)) u_run (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .start_i      (start_valid),
    .start_addr_i (start_addr),
    .halt_i       (wr_accept & wr_is_exit),
    .run_o        (core_run),
    .pc_o         (core_pc)
  );

  assign msg_valid   = ~q_empty;
  assign msg_kind    = head_msg.kind;
  assign msg_payload = head_msg.payload;
endmodule

// File: rtl/hostmsg_csr_unit_chk.sv
module hostmsg_csr_unit_chk #(
  parameter int          ADDR_W      = 12,
  parameter int          DATA_W      = 32,
  parameter int          PC_W        = 32,
  parameter int          DEPTH       = 4,
  parameter logic [11:0] TOHOST_ADDR = 12'h780
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       csr_wr_valid,
  input logic [ADDR_W-1:0]          csr_wr_addr,
  input logic [DATA_W-1:0]          csr_wr_data,
  input logic                       csr_wr_ready,
  input logic                       start_valid,
  input logic [PC_W-1:0]            start_addr,
  input logic                       core_run,
  input logic [PC_W-1:0]            core_pc,
  input logic                       msg_valid,
  input logic [1:0]                 msg_kind,
  input logic [15:0]                msg_payload,
  input logic                       msg_deq,
  input logic [$clog2(DEPTH+1)-1:0] occ
);
  logic exit_wr;
  assign exit_wr = core_run && csr_wr_valid && csr_wr_ready &&
                   (csr_wr_addr == ADDR_W'(TOHOST_ADDR)) && (csr_wr_data[17:16] == 2'd0);

  assert_run_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_run) |-> $past(start_valid));

  assert_pc_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_run) |-> (core_pc == $past(start_addr)));

  assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_run && start_valid) |=> $stable(core_pc));

  assert_exit_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exit_wr |=> !core_run);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= ($clog2(DEPTH+1))'(DEPTH));

  assert_stall_only_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_wr_ready |-> msg_valid);

  assert_no_msg_when_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_valid && !core_run) |=> !msg_valid);

  assert_head_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_deq) |=> (msg_valid && $stable(msg_kind) && $stable(msg_payload)));
endmodule

bind hostmsg_csr_unit hostmsg_csr_unit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PC_W(PC_W), .DEPTH(DEPTH), .TOHOST_ADDR(TOHOST_ADDR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .csr_wr_valid (csr_wr_valid),
  .csr_wr_addr  (csr_wr_addr),
  .csr_wr_data  (csr_wr_data),
  .csr_wr_ready (csr_wr_ready),
  .start_valid  (start_valid),
  .start_addr   (start_addr),
  .core_run     (core_run),
  .core_pc      (core_pc),
  .msg_valid    (msg_valid),
  .msg_kind     (msg_kind),
  .msg_payload  (msg_payload),
  .msg_deq      (msg_deq),
  .occ          (q_level)
);

// File: tb/hostmsg_csr_unit_test.sv
`timescale 1ns/1ps
module hostmsg_csr_unit_test;
  localparam logic [11:0] TOHOST = 12'h780;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_wr_valid;
  logic [11:0] csr_wr_addr;
  logic [31:0] csr_wr_data;
  logic        csr_wr_ready;
  logic        start_valid;
  logic [31:0] start_addr;
  logic        core_run;
  logic [31:0] core_pc;
  logic        msg_valid;
  logic [1:0]  msg_kind;
  logic [15:0] msg_payload;
  logic        msg_deq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hostmsg_csr_unit uut (
    .clk(clk), .rst_n(rst_n),
    .csr_wr_valid(csr_wr_valid), .csr_wr_addr(csr_wr_addr),
    .csr_wr_data(csr_wr_data), .csr_wr_ready(csr_wr_ready),
    .start_valid(start_valid), .start_addr(start_addr),
    .core_run(core_run), .core_pc(core_pc),
    .msg_valid(msg_valid), .msg_kind(msg_kind),
    .msg_payload(msg_payload), .msg_deq(msg_deq)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  // one CSR write; waits while not ready, returns at the negedge after it completes
  task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_wr_valid = 1'b1;
    csr_wr_addr  = a;
    csr_wr_data  = d;
    #1;
    while (!csr_wr_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    csr_wr_valid = 1'b0;
  endtask

  task automatic send_start(input logic [31:0] a);
    @(negedge clk);
    start_valid = 1'b1;
    start_addr  = a;
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  // checks the head message, then pops it
  task automatic pop_expect(input string tag, input logic [1:0] k, input logic [15:0] p);
    check({tag, " valid"}, 32'(msg_valid), 32'd1);
    check({tag, " kind"}, 32'(msg_kind), 32'(k));
    check({tag, " payload"}, 32'(msg_payload), 32'(p));
    msg_deq = 1'b1;
    @(negedge clk);
    msg_deq = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; csr_wr_valid = 1'b0; csr_wr_addr = '0; csr_wr_data = '0;
    start_valid = 1'b0; start_addr = '0; msg_deq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 run", 32'(core_run), 32'd0);
    check("R1 pc", core_pc, 32'd0);
    check("R1 msg_valid", 32'(msg_valid), 32'd0);
    check("R1 ready", 32'(csr_wr_ready), 32'd1);
  endtask

  task automatic t_before_start;
    csr_write(TOHOST, 32'h0001_0058);
    @(negedge clk);
    check("R10 no msg before start", 32'(msg_valid), 32'd0);
    check("R10 still stopped", 32'(core_run), 32'd0);
  endtask

  task automatic t_start;
    @(negedge clk);
    start_valid = 1'b1;
    start_addr  = 32'h0000_0200;
    #1;
    check("R2 run low before edge", 32'(core_run), 32'd0);
    @(negedge clk);
    start_valid = 1'b0;
    check("R2 run raised", 32'(core_run), 32'd1);
    check("R2 pc loaded", core_pc, 32'h0000_0200);
  endtask

  task automatic t_start_while_running;
    send_start(32'h0000_0400);
    check("R3 pc unchanged", core_pc, 32'h0000_0200);
    check("R3 still running", 32'(core_run), 32'd1);
  endtask

  task automatic t_other_csr;
    csr_write(12'h123, 32'h0001_0041);
    csr_write(12'h781, 32'h0000_0000);
    @(negedge clk);
    check("R7 no msg for other csr", 32'(msg_valid), 32'd0);
    check("R7 no halt for other csr", 32'(core_run), 32'd1);
  endtask

  task automatic t_format;
    csr_write(TOHOST, 32'hABCD_0041);   // bits 17:16 = 01
    pop_expect("R4 upper bits ignored", 2'd1, 16'h0041);
    csr_write(TOHOST, 32'hFFFD_BEEF);   // bits 17:16 = 01
    pop_expect("R4 payload", 2'd1, 16'hBEEF);
  endtask

  task automatic t_int_pair;
    csr_write(TOHOST, 32'h0002_5678);
    csr_write(TOHOST, 32'h0003_1234);
    pop_expect("R5 low half first", 2'd2, 16'h5678);
    pop_expect("R5 high half second", 2'd3, 16'h1234);
  endtask

  task automatic t_full;
    for (int i = 0; i < 4; i++) csr_write(TOHOST, 32'h0001_0030 + 32'(i));
    @(negedge clk);
    csr_wr_valid = 1'b1; csr_wr_addr = TOHOST; csr_wr_data = 32'h0001_0034;
    #1;
    check("R6 stall when full", 32'(csr_wr_ready), 32'd0);
    @(negedge clk);
    #1;
    check("R6 stall holds", 32'(csr_wr_ready), 32'd0);
    check("R11 head held", 32'(msg_payload), 32'h0030);
    msg_deq = 1'b1;
    @(negedge clk);
    msg_deq = 1'b0;
    #1;
    check("R6 ready after deq", 32'(csr_wr_ready), 32'd1);
    @(negedge clk);
    csr_wr_valid = 1'b0;
    for (int i = 1; i < 5; i++) pop_expect("R6 order kept", 2'd1, 16'h0030 + 16'(i));
    check("R6 drained", 32'(msg_valid), 32'd0);
  endtask

  task automatic t_exit_and_restart;
    csr_write(TOHOST, 32'h0000_0000);
    check("R8 run low after exit", 32'(core_run), 32'd0);
    csr_write(TOHOST, 32'h0001_0021);
    pop_expect("R8 pass code", 2'd0, 16'h0000);
    check("R9 no msg after exit", 32'(msg_valid), 32'd0);
    send_start(32'h0000_0300);
    check("R9 restart run", 32'(core_run), 32'd1);
    check("R9 restart pc", core_pc, 32'h0000_0300);
    csr_write(TOHOST, 32'hFFFC_0007);   // bits 17:16 = 00, fail code 7
    check("R8 run low after fail exit", 32'(core_run), 32'd0);
    pop_expect("R8 fail code", 2'd0, 16'h0007);
  endtask

  initial begin
    t_reset();
    t_before_start();
    t_start();
    t_start_while_running();
    t_other_csr();
    t_format();
    t_int_pair();
    t_full();
    t_exit_and_restart();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule